// File: doc/BRIEF.md
# ADC Channel Sequencer with Subgroups

This block sits on the control side of an analog-to-digital converter and decides which channel is converted next. A list of up to eight channel selectors is presented on a flat input bus. A single control word selects the operating mode, the number of list entries in use, the subgroup size, an enable and a soft reset. On a trigger the sequencer issues a start pulse and a channel number to the converter. It waits for the converter's done pulse, then moves to the next list entry.

There are three modes. One-shot converts the whole list once per trigger. Continuous restarts the list on its own after the final entry. Discontinuous converts one subgroup per trigger and carries on from where the previous subgroup stopped. When the list length is not a multiple of the subgroup size, the final subgroup is a shorter remainder. Any write that changes the control word aborts the work in progress and returns the sequencer to idle. The cycle that follows such a change ignores triggers.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word reads 0, the block is disabled, and `conv_start_o`, `busy_o`, `eog_o` and `eos_o` are 0. A trigger then has no effect.
- R2: Control word layout: bits [1:0] mode (0 one-shot, 1 continuous, 2 discontinuous, 3 same as one-shot), bit 2 enable, bit 3 soft reset, bits [6:4] list length minus one, bits [10:8] subgroup size minus one. Bits 7 and [15:11] are not stored and read as 0. A write whose stored value equals the current word does not abort anything.
- R3: A sequence converts list slots 0, 1, … up to the programmed length minus one, in that order. `conv_chan_o` equals the selector of the slot being converted, and a length field of 0 converts slot 0 only.
- R4: In one-shot mode, one trigger converts every list entry once and the block then goes idle. A trigger that arrives while a conversion is in progress is ignored.
- R5: In continuous mode, after the final entry's done the list restarts at slot 0 with no new trigger.
- R6: In discontinuous mode, each trigger converts (subgroup field + 1) entries, starting after the entry converted last. The final subgroup of the list holds only the entries that remain. `eog_o` pulses together with the done of each subgroup's last entry, and only in this mode.
- R7: `eos_o` pulses for one cycle together with the done of the final list entry, and the next sequence starts again at slot 0.
- R8: `conv_start_o` is a registered one-cycle pulse. The next start comes at the earliest in the cycle after the previous conversion's done, and `conv_chan_o` holds steady between starts.
- R9: A write that changes the control word forces the sequencer idle from the next cycle. It issues no further start and ignores a late done. The trigger input is also ignored in the cycle after the change.
- R10: While the enable bit is 0 the sequencer stays idle and ignores triggers.
- R11: While the soft reset bit is 1 the sequence state is held cleared and triggers are ignored. The rest of the control word keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 16 | Control word write data |
| ctl_word_o | output | 16 | Stored control word |
| list_chan_i | input | LIST_DEPTH*CHAN_W | Channel selector list, slot n at bits [n*CHAN_W +: CHAN_W] |
| trig_i | input | 1 | Conversion trigger |
| conv_start_o | output | 1 | Start pulse to the converter |
| conv_chan_o | output | CHAN_W | Channel to convert |
| conv_done_i | input | 1 | Converter done pulse |
| eog_o | output | 1 | End-of-subgroup flag |
| eos_o | output | 1 | End-of-sequence flag |
| busy_o | output | 1 | Sequence in progress |

## Verification
Some properties are checked on every cycle. The start is a single-cycle pulse, and the channel holds steady while a conversion is outstanding. A control change forces idle, and the cycle after it issues no start. The sequencer is never busy while disabled or in soft reset. The list index and subgroup counter stay inside their programmed bounds, and the index returns to slot 0 after an end-of-sequence. Other behaviour only the bench's scenarios can show. These are the exact slot order and channel values, the remainder size of the last subgroup across all 64 length and subgroup pairs, and the resumption point between triggers. The same scenarios cover continuous restart and the fact that a write of an unchanged value leaves a subgroup running.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int unsigned LIST_DEPTH = 8;
  localparam int unsigned IDX_W      = $clog2(LIST_DEPTH);

  // control word field positions
  localparam int unsigned MODE_LSB = 0;
  localparam int unsigned EN_BIT   = 2;
  localparam int unsigned SRST_BIT = 3;
  localparam int unsigned SEQ_LSB  = 4;
  localparam int unsigned SUB_LSB  = SEQ_LSB + IDX_W + 1;
  localparam int unsigned CTL_W    = SUB_LSB + IDX_W + 5;

  localparam logic [CTL_W-1:0] CTL_MASK =
      CTL_W'((1 << (SRST_BIT + 1)) - 1)
    | (CTL_W'((1 << IDX_W) - 1) << SEQ_LSB)
    | (CTL_W'((1 << IDX_W) - 1) << SUB_LSB);

  typedef enum logic [1:0] {
    MODE_ONCE  = 2'd0,
    MODE_LOOP  = 2'd1,
    MODE_SPLIT = 2'd2,
    MODE_RSVD  = 2'd3
  } seq_mode_e;

  typedef struct packed {
    seq_mode_e        mode;
    logic             en;
    logic             srst;
    logic [IDX_W-1:0] seq_last;
    logic [IDX_W-1:0] grp_last;
  } seq_cfg_t;

endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  output logic [CTL_W-1:0] ctl_q_o,
  output seq_cfg_t         cfg_o,
  output logic             chg_o,
  output logic             hold_o
);

  logic [CTL_W-1:0] ctl_q;
  logic [CTL_W-1:0] wmasked;
  logic             hold_q;

  // only a write that alters stored bits counts as a change
  assign wmasked = wdata_i & CTL_MASK;
  assign chg_o   = we_i && (wmasked != ctl_q);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      if (chg_o) begin
        ctl_q <= wmasked;
      end
      hold_q <= chg_o;
    end
  end

  assign ctl_q_o        = ctl_q;
  assign hold_o         = hold_q;
  assign cfg_o.mode     = seq_mode_e'(ctl_q[MODE_LSB +: 2]);
  assign cfg_o.en       = ctl_q[EN_BIT];
  assign cfg_o.srst     = ctl_q[SRST_BIT];
  assign cfg_o.seq_last = ctl_q[SEQ_LSB +: IDX_W];
  assign cfg_o.grp_last = ctl_q[SUB_LSB +: IDX_W];

endmodule

// File: rtl/adc_seq_chan_sel.sv
module adc_seq_chan_sel
  import adc_seq_pkg::*;
#(
  parameter int unsigned CHAN_W = 5
) (
  input  logic [LIST_DEPTH*CHAN_W-1:0] list_i,
  input  logic [IDX_W-1:0]             idx_i,
  output logic [CHAN_W-1:0]            chan_o
);

  logic [CHAN_W-1:0] slot [LIST_DEPTH];

  for (genvar g = 0; g < LIST_DEPTH; g++) begin : g_slot
    assign slot[g] = list_i[g*CHAN_W +: CHAN_W];
  end

  assign chan_o = slot[idx_i];

endmodule

// File: rtl/adc_seq_walker.sv
module adc_seq_walker
  import adc_seq_pkg::*;
#(
  parameter int unsigned CHAN_W = 5
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  seq_cfg_t          cfg_i,
  input  logic              abort_i,
  input  logic              hold_i,
  input  logic              trig_i,
  input  logic              done_i,
  input  logic [CHAN_W-1:0] sel_chan_i,
  output logic [IDX_W-1:0]  idx_next_o,
  output logic              start_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic              eog_o,
  output logic              eos_o,
  output logic              busy_o
);

  logic [IDX_W-1:0]  idx_q, idx_d, idx_adv;
  logic [IDX_W-1:0]  grp_q, grp_d;
  logic              busy_q, busy_d;
  logic              start_q, start_d;
  logic [CHAN_W-1:0] chan_q;
  logic              live, split, last_ent, grp_end, fin;

  assign live     = cfg_i.en && !cfg_i.srst;
  assign split    = (cfg_i.mode == MODE_SPLIT);
  assign last_ent = (idx_q == cfg_i.seq_last);
  assign grp_end  = last_ent || (grp_q == cfg_i.grp_last);
  assign fin      = busy_q && done_i && live && !abort_i;
  assign idx_adv  = last_ent ? '0 : idx_q + IDX_W'(1);

  assign eos_o = fin && last_ent;
  assign eog_o = fin && split && grp_end;

  // next-state
  always_comb begin
    idx_d   = idx_q;
    grp_d   = grp_q;
    busy_d  = busy_q;
    start_d = 1'b0;
    if (abort_i || !live) begin
      idx_d  = '0;
      grp_d  = '0;
      busy_d = 1'b0;
    end else if (!busy_q) begin
      if (trig_i && !hold_i) begin
        busy_d  = 1'b1;
        start_d = 1'b1;
      end
    end else if (done_i) begin
      idx_d = idx_adv;
      if (split) begin
        if (grp_end) begin
          grp_d  = '0;
          busy_d = 1'b0;
        end else begin
          grp_d   = grp_q + IDX_W'(1);
          start_d = 1'b1;
        end
      end else if (last_ent && (cfg_i.mode != MODE_LOOP)) begin
        busy_d = 1'b0;
      end else begin
        start_d = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      grp_q   <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      chan_q  <= '0;
    end else begin
      idx_q   <= idx_d;
      grp_q   <= grp_d;
      busy_q  <= busy_d;
      start_q <= start_d;
      if (start_d) begin
        chan_q <= sel_chan_i;
      end
    end
  end

  assign idx_next_o = idx_d;
  assign start_o    = start_q;
  assign chan_o     = chan_q;
  assign busy_o     = busy_q;

  // R8
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    start_q |=> !start_q);

  // R8
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_q && !start_q) |-> $stable(chan_q));

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    abort_i |=> (!busy_q && !start_q));

  // R9
  holdoff_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    hold_i |=> !start_q);

  // R10
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !cfg_i.en |-> !busy_q);

  // R11
  srst_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    cfg_i.srst |-> !busy_q);

  // R7
  eos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    eos_o |=> (idx_q == '0));

  // R3
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    idx_q <= cfg_i.seq_last);

  // R6
  grp_bound_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (grp_q <= cfg_i.grp_last) && (busy_q || (grp_q == '0)));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned CHAN_W = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we_i,
  input  logic [CTL_W-1:0]             cfg_wdata_i,
  output logic [CTL_W-1:0]             ctl_word_o,
  input  logic [LIST_DEPTH*CHAN_W-1:0] list_chan_i,
  input  logic                         trig_i,
  output logic                         conv_start_o,
  output logic [CHAN_W-1:0]            conv_chan_o,
  input  logic                         conv_done_i,
  output logic                         eog_o,
  output logic                         eos_o,
  output logic                         busy_o
);

  logic [1:0]        rst_pipe;
  logic              rst_loc_n;
  seq_cfg_t          cfg;
  logic              chg;
  logic              hold;
  logic [IDX_W-1:0]  idx_next;
  logic [CHAN_W-1:0] sel_chan;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_loc_n = rst_pipe[1];

  adc_seq_cfg u_cfg (
    .clk     (clk),
    .rst_ni  (rst_loc_n),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .ctl_q_o (ctl_word_o),
    .cfg_o   (cfg),
    .chg_o   (chg),
    .hold_o  (hold)
  );

  adc_seq_chan_sel #(.CHAN_W(CHAN_W)) u_sel (
    .list_i (list_chan_i),
    .idx_i  (idx_next),
    .chan_o (sel_chan)
  );

  adc_seq_walker #(.CHAN_W(CHAN_W)) u_walk (
    .clk        (clk),
    .rst_ni     (rst_loc_n),
    .cfg_i      (cfg),
    .abort_i    (chg),
    .hold_i     (hold),
    .trig_i     (trig_i),
    .done_i     (conv_done_i),
    .sel_chan_i (sel_chan),
    .idx_next_o (idx_next),
    .start_o    (conv_start_o),
    .chan_o     (conv_chan_o),
    .eog_o      (eog_o),
    .eos_o      (eos_o),
    .busy_o     (busy_o)
  );

endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;

  localparam int DEPTH = 8;
  localparam int CW    = 5;

  logic              clk;
  logic              rst_n;
  logic              cfg_we;
  logic [15:0]       cfg_wdata;
  logic [15:0]       ctl_word;
  logic [DEPTH*CW-1:0] list_chan;
  logic              trig;
  logic              conv_start;
  logic [CW-1:0]     conv_chan;
  logic              conv_done;
  logic              eog, eos, busy;

  int n_chk;
  int n_fail;
  bit finished;

  adc_seq_ctrl #(.CHAN_W(CW)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we_i     (cfg_we),
    .cfg_wdata_i  (cfg_wdata),
    .ctl_word_o   (ctl_word),
    .list_chan_i  (list_chan),
    .trig_i       (trig),
    .conv_start_o (conv_start),
    .conv_chan_o  (conv_chan),
    .conv_done_i  (conv_done),
    .eog_o        (eog),
    .eos_o        (eos),
    .busy_o       (busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int slot_chan(int i);
    return (i * 7 + 3) % 32;
  endfunction

  function automatic logic [15:0] mk(int mode, int en, int srst, int sl, int gl);
    return 16'((mode & 3) | ((en & 1) << 2) | ((srst & 1) << 3) | ((sl & 7) << 4) | ((gl & 7) << 8));
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(logic [15:0] w);
    cfg_wdata = w;
    cfg_we    = 1'b1;
    step();
    cfg_we    = 1'b0;
    step();
  endtask

  task automatic kick();
    trig = 1'b1;
    step();
    trig = 1'b0;
  endtask

  // called at the negedge where a start is expected to be visible
  task automatic conv(int idx, int more, int eog_e, int eos_e, int poke);
    chk("R8 start", int'(conv_start), 1);
    chk("R3 chan", int'(conv_chan), slot_chan(idx));
    if (poke != 0) trig = 1'b1;
    step();
    trig = 1'b0;
    chk("R8 single pulse / R4 retrigger ignored", int'(conv_start), 0);
    step();
    conv_done = 1'b1;
    #1;
    chk("R7 eos", int'(eos), eos_e);
    chk("R6 eog", int'(eog), eog_e);
    step();
    conv_done = 1'b0;
    chk("R8 R5 next start", int'(conv_start), more);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; trig = 1'b0; conv_done = 1'b0;
    for (int i = 0; i < DEPTH; i++) list_chan[i*CW +: CW] = CW'(slot_chan(i));
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    chk("R1 ctl word", int'(ctl_word), 0);
    chk("R1 start", int'(conv_start), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 eos", int'(eos), 0);
    chk("R1 eog", int'(eog), 0);
    kick();
    chk("R1 trigger ignored when disabled", int'(conv_start), 0);

    // R10 explicit disable with other fields set
    wr(mk(0, 0, 0, 3, 0));
    chk("R10 ctl word", int'(ctl_word), int'(mk(0, 0, 0, 3, 0)));
    kick();
    chk("R10 no start", int'(conv_start), 0);
    step();
    chk("R10 idle", int'(busy), 0);

    // R4 R3 one-shot sweep, modes 0 and 3
    for (int m = 0; m < 2; m++) begin
      for (int sl = 0; sl < DEPTH; sl++) begin
        wr(mk(m == 0 ? 0 : 3, 1, 0, sl, 0));
        for (int rnd = 0; rnd < 2; rnd++) begin
          kick();
          for (int i = 0; i <= sl; i++)
            conv(i, (i != sl) ? 1 : 0, 0, (i == sl) ? 1 : 0, (rnd == 0) ? 1 : 0);
          chk("R4 idle after list", int'(busy), 0);
        end
      end
    end

    // R6 R7 discontinuous sweep over all length/subgroup pairs
    for (int sl = 0; sl < DEPTH; sl++) begin
      for (int gl = 0; gl < DEPTH; gl++) begin
        int idx;
        int left;
        int cnt;
        wr(mk(2, 1, 0, sl, gl));
        idx = 0;
        for (int rnd = 0; rnd < 2; rnd++) begin
          left = sl + 1;
          while (left > 0) begin
            cnt = (left < gl + 1) ? left : gl + 1;
            kick();
            for (int k = 0; k < cnt; k++) begin
              conv(idx, (k != cnt - 1) ? 1 : 0, (k == cnt - 1) ? 1 : 0, (idx == sl) ? 1 : 0, 0);
              idx = (idx == sl) ? 0 : idx + 1;
            end
            left = left - cnt;
            chk("R6 idle between subgroups", int'(busy), 0);
          end
          chk("R7 index back at slot 0", idx, 0);
        end
      end
    end

    // R5 continuous restart, then R9 abort
    wr(mk(1, 1, 0, 2, 0));
    kick();
    for (int n = 0; n < 8; n++) conv(n % 3, 1, 0, (n % 3 == 2) ? 1 : 0, 0);
    chk("R5 restart chan", int'(conv_chan), slot_chan(8 % 3));
    cfg_wdata = mk(1, 1, 0, 3, 0);
    cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
    chk("R9 idle after change", int'(busy), 0);
    chk("R9 no start after change", int'(conv_start), 0);
    step();
    conv_done = 1'b1;
    #1;
    chk("R9 late done ignored eos", int'(eos), 0);
    step();
    conv_done = 1'b0;
    chk("R9 late done no start", int'(conv_start), 0);

    // R9 trigger ignored in the cycle after a change
    cfg_wdata = mk(0, 1, 0, 1, 0);
    cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
    trig = 1'b1;
    step();
    trig = 1'b0;
    chk("R9 holdoff trigger ignored", int'(conv_start), 0);
    step();
    kick();
    conv(0, 1, 0, 0, 0);
    conv(1, 0, 0, 1, 0);

    // R2 write of unchanged value (reserved bits set) does not abort
    wr(mk(2, 1, 0, 5, 1));
    kick();
    conv(0, 1, 0, 0, 0);
    conv(1, 0, 1, 0, 0);
    wr(mk(2, 1, 0, 5, 1) | 16'hF880);
    chk("R2 reserved bits read 0", int'(ctl_word), int'(mk(2, 1, 0, 5, 1)));
    kick();
    chk("R2 resumes at slot 2", int'(conv_chan), slot_chan(2));
    cfg_wdata = mk(2, 1, 0, 5, 1);
    cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
    chk("R2 same write keeps busy", int'(busy), 1);
    step();
    conv_done = 1'b1;
    #1;
    chk("R2 no eog mid subgroup", int'(eog), 0);
    step();
    conv_done = 1'b0;
    chk("R2 subgroup continues", int'(conv_start), 1);
    chk("R2 subgroup chan", int'(conv_chan), slot_chan(3));
    step();
    step();
    conv_done = 1'b1;
    #1;
    chk("R6 eog after resumed subgroup", int'(eog), 1);
    step();
    conv_done = 1'b0;

    // R11 soft reset keeps word, blocks triggers
    wr(mk(2, 1, 0, 7, 2));
    kick();
    conv(0, 1, 0, 0, 0);
    conv(1, 1, 0, 0, 0);
    conv(2, 0, 1, 0, 0);
    wr(mk(2, 1, 1, 7, 2));
    chk("R11 word retained", int'(ctl_word), int'(mk(2, 1, 1, 7, 2)));
    kick();
    chk("R11 trigger ignored", int'(conv_start), 0);
    step();
    chk("R11 idle", int'(busy), 0);
    wr(mk(2, 1, 0, 7, 2));
    kick();
    conv(0, 1, 0, 0, 0);
    conv(1, 1, 0, 0, 0);
    conv(2, 0, 1, 0, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule